// File: doc/BRIEF.md
# Operand Effective Address Generator

This block turns an addressing-mode code, a register number, an operand size, the address of the current opcode word and one caller-supplied extension value into a 24-bit operand address. For the two stepping modes it also returns the new value of the chosen address register, so the register file can be updated in the same cycle as the address is used.

The caller presents all eight address registers and all eight data registers as flat buses. It also supplies the extension value already fetched. A request is taken when `req_valid` is high at a rising clock edge, and the results are registered and appear after that edge. The block fetches nothing, delivers no register-direct or immediate operands and makes no memory access.

Top module: `ea_calc`

## Requirements
- R1: While `rst_n` is low, `ea_valid`, `wb_valid`, `ea_addr`, `wb_reg` and `wb_value` are all zero.
- R2: Mode 0 (register indirect) gives `ea_addr` = low 24 bits of address register `reg_sel`. For every mode other than 1 and 2, `wb_valid` stays low.
- R3: Mode 1 (post-increment) gives `ea_addr` = the register's value before stepping. It also raises `wb_valid` with `wb_reg` = `reg_sel` and `wb_value` = the register plus the step. The step is 1, 2 or 4 for `size` 00, 01 or 10 (11 steps by 4).
- R4: Mode 2 (pre-decrement) gives `wb_value` = the register minus the step, using the step sizes of R3. `ea_addr` is the low 24 bits of that decremented value, and `wb_valid` is raised. The subtraction wraps modulo 2^32.
- R5: Mode 3 gives the address register plus `ext[15:0]`, sign-extended. Every final sum is truncated to 24 bits.
- R6: Mode 4 adds three terms: the address register, the index register and `ext[7:0]` sign-extended. `idx_sel[3]`=1 picks address register `idx_sel[2:0]`, and 0 picks data register `idx_sel[2:0]`. With `idx_long`=1 the index is used as its full 32 bits; with 0 it is its low 16 bits, sign-extended.
- R7: Modes 5 and 6 work like modes 3 and 4, but use `pc`+2 (the address of the extension word) in place of the address register. Example: opcode at 1000, index 6 and offset 100 give 1108.
- R8: Mode 7 (absolute short) gives `ext[15:0]` sign-extended to 24 bits, so only addresses 000000–007FFF and FF8000–FFFFFF are reachable.
- R9: Mode 8 (absolute long) gives `ea_addr` = `ext[23:0]`.
- R10: After a cycle with `req_valid` low, or with a mode code of 9 to 15, `ea_valid` and `wb_valid` are low. Results of a taken request appear after the clock edge that took it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe |
| mode | input | 4 | Addressing-mode code 0–8 |
| size | input | 2 | Operand size: 00 byte, 01 word, 10 long |
| reg_sel | input | 3 | Base address register number |
| idx_sel | input | 4 | Index register: bit 3 selects address/data file, bits 2:0 number |
| idx_long | input | 1 | 1: full 32-bit index, 0: sign-extended 16-bit index |
| pc | input | 24 | Address of the opcode word |
| ext | input | 32 | Extension value (displacement or absolute address) |
| a_regs | input | 256 | Address registers, register n in bits 32n+31:32n |
| d_regs | input | 256 | Data registers, register n in bits 32n+31:32n |
| ea_valid | output | 1 | Effective address valid |
| ea_addr | output | 24 | Effective address |
| wb_valid | output | 1 | Register writeback valid |
| wb_reg | output | 3 | Address register to write back |
| wb_value | output | 32 | New address register value |

## Verification
In the stepping modes, address generation and register writeback happen in the same cycle from one request. These two results must be told apart. For post-increment, the bench judges that the address equals the old register value while the writeback carries the stepped one. For pre-decrement, it judges that both equal the decremented value. Both are provoked with all three sizes. They are also provoked at the wrap points: a register at zero that is pre-decremented, and a register near the top of the 24-bit space that is post-incremented past it. There the 32-bit writeback and the truncated 24-bit address must disagree in their upper bits.

// File: rtl/ea_calc.sv
module ea_calc #(
  parameter int AW   = 24,
  parameter int DW   = 32,
  parameter int NREG = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic [3:0]               mode,
  input  logic [1:0]               size,
  input  logic [$clog2(NREG)-1:0]  reg_sel,
  input  logic [$clog2(NREG):0]    idx_sel,
  input  logic                     idx_long,
  input  logic [AW-1:0]            pc,
  input  logic [DW-1:0]            ext,
  input  logic [NREG*DW-1:0]       a_regs,
  input  logic [NREG*DW-1:0]       d_regs,
  output logic                     ea_valid,
  output logic [AW-1:0]            ea_addr,
  output logic                     wb_valid,
  output logic [$clog2(NREG)-1:0]  wb_reg,
  output logic [DW-1:0]            wb_value
);
  localparam int RW = $clog2(NREG);
  localparam logic [3:0] M_IND  = 4'd0, M_INC  = 4'd1, M_DEC  = 4'd2,
                         M_D16  = 4'd3, M_IDX  = 4'd4, M_PCD  = 4'd5,
                         M_PCX  = 4'd6, M_ABSW = 4'd7, M_ABSL = 4'd8;

  logic [DW-1:0] base_a, idx_raw, idx_val, step, stepped;
  logic [DW-1:0] disp16, disp8, pc_base;
  logic [DW-1:0] op_base, op_idx, op_off, sum;
  logic          hit, wb;

  assign base_a  = a_regs[reg_sel*DW +: DW];
  assign idx_raw = idx_sel[RW] ? a_regs[idx_sel[RW-1:0]*DW +: DW]
                               : d_regs[idx_sel[RW-1:0]*DW +: DW];
  assign idx_val = idx_long ? idx_raw : {{(DW-16){idx_raw[15]}}, idx_raw[15:0]};
  assign disp16  = {{(DW-16){ext[15]}}, ext[15:0]};
  assign disp8   = {{(DW-8){ext[7]}}, ext[7:0]};
  assign pc_base = {{(DW-AW){1'b0}}, pc + AW'(2)};
  assign step    = (size == 2'b00) ? DW'(1) : (size == 2'b01) ? DW'(2) : DW'(4);
  assign stepped = (mode == M_DEC) ? base_a - step : base_a + step;

  always_comb begin
    hit     = 1'b1;
    wb      = 1'b0;
    op_base = base_a;
    op_idx  = '0;
    op_off  = '0;
    case (mode)
      M_IND:  ;
      M_INC:  wb = 1'b1;
      M_DEC:  begin op_base = stepped; wb = 1'b1; end
      M_D16:  op_off = disp16;
      M_IDX:  begin op_off = disp8; op_idx = idx_val; end
      M_PCD:  begin op_base = pc_base; op_off = disp16; end
      M_PCX:  begin op_base = pc_base; op_off = disp8; op_idx = idx_val; end
      M_ABSW: begin op_base = '0; op_off = disp16; end
      M_ABSL: op_base = ext;
      default: hit = 1'b0;
    endcase
  end

  assign sum = op_base + op_idx + op_off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ea_valid <= 1'b0;
      ea_addr  <= '0;
      wb_valid <= 1'b0;
      wb_reg   <= '0;
      wb_value <= '0;
    end else begin
      ea_valid <= req_valid & hit;
      wb_valid <= req_valid & wb;
      if (req_valid & hit) ea_addr <= sum[AW-1:0];
      if (req_valid & wb) begin
        wb_reg   <= reg_sel;
        wb_value <= stepped;
      end
    end
  end
endmodule

// File: rtl/ea_calc_chk.sv
module ea_calc_chk #(
  parameter int AW   = 24,
  parameter int DW   = 32,
  parameter int NREG = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     req_valid,
  input logic [3:0]               mode,
  input logic [1:0]               size,
  input logic [$clog2(NREG)-1:0]  reg_sel,
  input logic [DW-1:0]            ext,
  input logic [NREG*DW-1:0]       a_regs,
  input logic                     ea_valid,
  input logic [AW-1:0]            ea_addr,
  input logic                     wb_valid,
  input logic [$clog2(NREG)-1:0]  wb_reg,
  input logic [DW-1:0]            wb_value
);
  logic [DW-1:0] cur, amt;
  assign cur = a_regs[reg_sel*DW +: DW];
  assign amt = size[1] ? DW'(4) : size[0] ? DW'(2) : DW'(1);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !ea_valid && !wb_valid); // R10
  AST_NO_STRAY_WB: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && mode != 4'd1 && mode != 4'd2 |=> !wb_valid); // R2
  AST_POSTINC_OLD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && mode == 4'd1 |=> wb_valid && ea_valid && ea_addr == $past(cur[AW-1:0])
      && wb_value == $past(cur) + $past(amt) && wb_reg == $past(reg_sel)); // R3
  AST_PREDEC_NEW_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && mode == 4'd2 |=> wb_valid && ea_addr == wb_value[AW-1:0]
      && wb_value == $past(cur) - $past(amt)); // R4
  AST_SHORT_TWO_PAGES: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && mode == 4'd7 |=> ea_valid
      && (ea_addr[AW-1:15] == '0 || ea_addr[AW-1:15] == '1)); // R8
  AST_LONG_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && mode == 4'd8 |=> ea_valid && ea_addr == $past(ext[AW-1:0])); // R9
  AST_BAD_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && mode > 4'd8 |=> !ea_valid); // R10
endmodule

bind ea_calc ea_calc_chk #(.AW(AW), .DW(DW), .NREG(NREG)) chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mode(mode), .size(size),
  .reg_sel(reg_sel), .ext(ext), .a_regs(a_regs), .ea_valid(ea_valid),
  .ea_addr(ea_addr), .wb_valid(wb_valid), .wb_reg(wb_reg), .wb_value(wb_value));

// File: tb/ea_calc_test.sv
module ea_calc_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [3:0]  mode = '0;
  logic [1:0]  size = '0;
  logic [2:0]  reg_sel = '0;
  logic [3:0]  idx_sel = '0;
  logic        idx_long = 1'b0;
  logic [23:0] pc = '0;
  logic [31:0] ext = '0;
  logic [255:0] a_regs, d_regs;
  logic        ea_valid, wb_valid;
  logic [23:0] ea_addr;
  logic [2:0]  wb_reg;
  logic [31:0] wb_value;
  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  assign a_regs = {32'h0040_0000, 32'h0000_8000, 32'h0020_0000, 32'h1234_5678,
                   32'h0000_0000, 32'h00FF_FFFE, 32'h0000_0006, 32'h0000_1000};
  assign d_regs = {32'h0, 32'h0, 32'h0, 32'h0, 32'h0,
                   32'h0000_0010, 32'h0001_0004, 32'h0000_FFFE};

  ea_calc uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mode(mode), .size(size),
    .reg_sel(reg_sel), .idx_sel(idx_sel), .idx_long(idx_long), .pc(pc), .ext(ext),
    .a_regs(a_regs), .d_regs(d_regs), .ea_valid(ea_valid), .ea_addr(ea_addr),
    .wb_valid(wb_valid), .wb_reg(wb_reg), .wb_value(wb_value));

  // tag mode size rsel xsel xl pc ext | ev ea wv wval
  localparam int NV = 24;
  localparam logic [131:0] VEC [NV] = '{
    {4'd2, 4'd0, 2'd0, 3'd4, 4'd0, 1'b0, 24'h0, 32'h0, 1'b1, 24'h345678, 1'b0, 32'h0},          // R2
    {4'd3, 4'd1, 2'd0, 3'd0, 4'd0, 1'b0, 24'h0, 32'h0, 1'b1, 24'h001000, 1'b1, 32'h0000_1001},  // R3 byte
    {4'd3, 4'd1, 2'd1, 3'd0, 4'd0, 1'b0, 24'h0, 32'h0, 1'b1, 24'h001000, 1'b1, 32'h0000_1002},  // R3 word
    {4'd3, 4'd1, 2'd2, 3'd0, 4'd0, 1'b0, 24'h0, 32'h0, 1'b1, 24'h001000, 1'b1, 32'h0000_1004},  // R3 long
    {4'd3, 4'd1, 2'd2, 3'd2, 4'd0, 1'b0, 24'h0, 32'h0, 1'b1, 24'hFFFFFE, 1'b1, 32'h0100_0002},  // R3 top wrap
    {4'd4, 4'd2, 2'd2, 3'd0, 4'd0, 1'b0, 24'h0, 32'h0, 1'b1, 24'h000FFC, 1'b1, 32'h0000_0FFC},  // R4 long
    {4'd4, 4'd2, 2'd0, 3'd3, 4'd0, 1'b0, 24'h0, 32'h0, 1'b1, 24'hFFFFFF, 1'b1, 32'hFFFF_FFFF},  // R4 zero wrap
    {4'd4, 4'd2, 2'd1, 3'd6, 4'd0, 1'b0, 24'h0, 32'h0, 1'b1, 24'h007FFE, 1'b1, 32'h0000_7FFE},  // R4 word
    {4'd5, 4'd3, 2'd0, 3'd5, 4'd0, 1'b0, 24'h0, 32'h0000_FFF0, 1'b1, 24'h1FFFF0, 1'b0, 32'h0},  // R5 negative
    {4'd5, 4'd3, 2'd0, 3'd0, 4'd0, 1'b0, 24'h0, 32'h0000_7FFF, 1'b1, 24'h008FFF, 1'b0, 32'h0},  // R5 positive
    {4'd5, 4'd3, 2'd0, 3'd4, 4'd0, 1'b0, 24'h0, 32'h0, 1'b1, 24'h345678, 1'b0, 32'h0},          // R5 truncation
    {4'd6, 4'd4, 2'd0, 3'd0, 4'd1, 1'b0, 24'h0, 32'h0000_0080, 1'b1, 24'h000F84, 1'b0, 32'h0},  // R6 D1 word
    {4'd6, 4'd4, 2'd0, 3'd0, 4'd1, 1'b1, 24'h0, 32'h0000_007F, 1'b1, 24'h011083, 1'b0, 32'h0},  // R6 D1 long
    {4'd6, 4'd4, 2'd0, 3'd0, 4'd0, 1'b0, 24'h0, 32'h0000_0010, 1'b1, 24'h00100E, 1'b0, 32'h0},  // R6 D0 word
    {4'd6, 4'd4, 2'd0, 3'd0, 4'd0, 1'b1, 24'h0, 32'h0000_0010, 1'b1, 24'h01100E, 1'b0, 32'h0},  // R6 D0 long
    {4'd6, 4'd4, 2'd0, 3'd5, 4'd15, 1'b1, 24'h0, 32'h0000_00FF, 1'b1, 24'h5FFFFF, 1'b0, 32'h0}, // R6 A7 long
    {4'd7, 4'd6, 2'd0, 3'd0, 4'd9, 1'b0, 24'd1000, 32'd100, 1'b1, 24'd1108, 1'b0, 32'h0},       // R7 index
    {4'd7, 4'd5, 2'd0, 3'd0, 4'd0, 1'b0, 24'h002000, 32'h0000_8000, 1'b1, 24'hFFA002, 1'b0, 32'h0}, // R7 disp
    {4'd8, 4'd7, 2'd0, 3'd0, 4'd0, 1'b0, 24'h0, 32'h0000_7FFF, 1'b1, 24'h007FFF, 1'b0, 32'h0},  // R8 low page
    {4'd8, 4'd7, 2'd0, 3'd0, 4'd0, 1'b0, 24'h0, 32'h0000_8000, 1'b1, 24'hFF8000, 1'b0, 32'h0},  // R8 high page
    {4'd8, 4'd7, 2'd0, 3'd0, 4'd0, 1'b0, 24'h0, 32'h1234_1234, 1'b1, 24'h001234, 1'b0, 32'h0},  // R8 upper ignored
    {4'd9, 4'd8, 2'd0, 3'd0, 4'd0, 1'b0, 24'h0, 32'hAB12_3456, 1'b1, 24'h123456, 1'b0, 32'h0},  // R9
    {4'd10, 4'd9, 2'd0, 3'd0, 4'd0, 1'b0, 24'h0, 32'h0, 1'b0, 24'h0, 1'b0, 32'h0},              // R10
    {4'd10, 4'd15, 2'd2, 3'd1, 4'd0, 1'b0, 24'h0, 32'h0, 1'b0, 24'h0, 1'b0, 32'h0}              // R10
  };

  task automatic check_out(input int tag, input logic ev, input logic [23:0] ea,
                           input logic wv, input logic [2:0] wr, input logic [31:0] wval);
    checks++;
    if (ea_valid !== ev || (ev && ea_addr !== ea) || wb_valid !== wv ||
        (wv && (wb_value !== wval || wb_reg !== wr))) begin
      fails++;
      $display("FAIL R%0d: got ev=%b ea=%h wv=%b wr=%0d wval=%h, expected ev=%b ea=%h wv=%b wr=%0d wval=%h",
               tag, ea_valid, ea_addr, wb_valid, wb_reg, wb_value, ev, ea, wv, wr, wval);
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_out(1, 1'b0, 24'h0, 1'b0, 3'd0, 32'h0); // R1
    checks++;
    if (ea_addr !== 24'h0 || wb_value !== 32'h0) begin
      fails++;
      $display("FAIL R1: got ea=%h wval=%h, expected 0 0", ea_addr, wb_value);
    end
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      req_valid = 1'b1;
      mode = VEC[i][127:124]; size = VEC[i][123:122]; reg_sel = VEC[i][121:119];
      idx_sel = VEC[i][118:115]; idx_long = VEC[i][114]; pc = VEC[i][113:90];
      ext = VEC[i][89:58];
      @(negedge clk);
      check_out(int'(VEC[i][131:128]), VEC[i][57], VEC[i][56:33], VEC[i][32],
                VEC[i][121:119], VEC[i][31:0]);
    end
    // R10: idle cycle after a stepping request drops both strobes
    mode = 4'd1; reg_sel = 3'd0; size = 2'd0;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    check_out(10, 1'b0, 24'h0, 1'b0, 3'd0, 32'h0);
    // R1: asynchronous reset in mid-run clears a pending stepping result
    req_valid = 1'b1; mode = 4'd2; reg_sel = 3'd7; size = 2'd2;
    @(negedge clk);
    check_out(4, 1'b1, 24'h3FFFFC, 1'b1, 3'd7, 32'h003F_FFFC); // R4
    req_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    check_out(1, 1'b0, 24'h0, 1'b0, 3'd0, 32'h0);
    checks++;
    if (ea_addr !== 24'h0 || wb_value !== 32'h0 || wb_reg !== 3'd0) begin
      fails++;
      $display("FAIL R1: got ea=%h wr=%0d wval=%h, expected 0 0 0", ea_addr, wb_reg, wb_value);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule